// File: doc/BRIEF.md
# Dual-Width SHA-2 Message Schedule Unit

This block extends a SHA-2 message schedule by one group of four words per operation. A request carries a window of the sixteen most recent schedule words W[t]..W[t+15] and a width select. The response carries W[t+16]..W[t+19]. The same datapath serves 32-bit words (SHA-256) and 64-bit words (SHA-512). Only the rotate and shift amounts of the two small sigma functions change with the width.

Inside one group, the third and fourth new words need the first and second new words as their sigma-one operand. The four lane adders are therefore chained inside a single combinational stage. Message storage, round constants and the compression rounds are handled elsewhere. Requests and responses each use a valid/ready handshake. Every accepted request produces exactly one registered response group.

Top module: `sha2_sched_unit`

## Requirements
- R1: With req_wide = 0 (32-bit mode), result word k (rsp_words bits 64k+63..64k) equals W[t+16+k] = s1(W[t+14+k]) + W[t+9+k] + s0(W[t+1+k]) + W[t+k], where the window word W[t+i] is req_window bits 64i+63..64i. Here s0(x) = rotr7 ^ rotr18 ^ (x >> 3) and s1(x) = rotr17 ^ rotr19 ^ (x >> 10), both on 32-bit x.
- R2: With req_wide = 1 (64-bit mode), the same recurrence holds with 64-bit words, s0(x) = rotr1 ^ rotr8 ^ (x >> 7) and s1(x) = rotr19 ^ rotr61 ^ (x >> 6).
- R3: Every addition wraps modulo 2^32 in 32-bit mode and modulo 2^64 in 64-bit mode. No carry leaves the word.
- R4: Result words 2 and 3 use the freshly computed W[t+16] and W[t+17] as their s1 operand. They do not use any window word for that operand.
- R5: In 32-bit mode, bits 63..32 of every window lane have no effect on the result, and bits 63..32 of every result lane are zero.
- R6: While rst_n is low and after its release, rsp_valid is 0 and req_ready is 1 until the first request is accepted.
- R7: req_ready equals (not rsp_valid) or rsp_ready. A request accepted at a clock edge raises rsp_valid with its result at the next edge, a latency of one cycle.
- R8: While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays 1 and rsp_words stays unchanged.
- R9: Each accepted request yields exactly one response, in order. A response is consumed and a new request accepted in the same cycle sustains one group per cycle. A consumed response with no new request drops rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request carries a window |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_wide | input | 1 | 1 = 64-bit words, 0 = 32-bit words |
| req_window | input | 1024 | Sixteen 64-bit lanes, lane i = W[t+i] |
| rsp_valid | output | 1 | Result group is held on rsp_words |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_words | output | 256 | Four 64-bit lanes, lane k = W[t+16+k] |

## Verification
The bench goes after the chained words 2 and 3. A design that fed a window word into their sigma-one operand would get the first two words right and the last two wrong. All-ones windows force carries out of every adder. A narrow datapath that let a carry escape would then show nonzero upper result bits, and so would a design that read the garbage placed in the upper halves of the 32-bit-mode inputs. A random consumer that stalls and drains at the same time as new requests arrive exposes a result register that moves while stalled, a response that is lost or repeated, and a ready that ignores the draining slot.

// File: rtl/sha2_sched_pkg.sv
package sha2_sched_pkg;

  localparam int unsigned LANE_W  = 64;
  localparam int unsigned HALF_W  = 32;
  localparam int unsigned WIN_N   = 16;
  localparam int unsigned GROUP_N = 4;

  // sigma amounts, 32-bit words
  localparam int unsigned N_S0_RA = 7;
  localparam int unsigned N_S0_RB = 18;
  localparam int unsigned N_S0_SH = 3;
  localparam int unsigned N_S1_RA = 17;
  localparam int unsigned N_S1_RB = 19;
  localparam int unsigned N_S1_SH = 10;
  // sigma amounts, 64-bit words
  localparam int unsigned W_S0_RA = 1;
  localparam int unsigned W_S0_RB = 8;
  localparam int unsigned W_S0_SH = 7;
  localparam int unsigned W_S1_RA = 19;
  localparam int unsigned W_S1_RB = 61;
  localparam int unsigned W_S1_SH = 6;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [HALF_W-1:0] half_t;

  typedef enum logic {
    WIDTH_NARROW = 1'b0,
    WIDTH_WIDE   = 1'b1
  } width_e;

  function automatic half_t ror_half(input half_t v, input int unsigned n);
    return (v >> n) | (v << (HALF_W - n));
  endfunction

  function automatic lane_t ror_lane(input lane_t v, input int unsigned n);
    return (v >> n) | (v << (LANE_W - n));
  endfunction

  function automatic half_t mix_half(input half_t v, input int unsigned ra,
                                     input int unsigned rb, input int unsigned sh);
    return ror_half(v, ra) ^ ror_half(v, rb) ^ (v >> sh);
  endfunction

  function automatic lane_t mix_lane(input lane_t v, input int unsigned ra,
                                     input int unsigned rb, input int unsigned sh);
    return ror_lane(v, ra) ^ ror_lane(v, rb) ^ (v >> sh);
  endfunction

  function automatic lane_t width_mask(input width_e w);
    return (w == WIDTH_WIDE) ? '1 : {{(LANE_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  endfunction

endpackage

// File: rtl/sha2_sigma.sv
module sha2_sigma
  import sha2_sched_pkg::*;
#(
  parameter bit IS_SIG1 = 1'b0
) (
  input  width_e width,
  input  lane_t  x,
  output lane_t  y
);

  localparam int unsigned NRA = IS_SIG1 ? N_S1_RA : N_S0_RA;
  localparam int unsigned NRB = IS_SIG1 ? N_S1_RB : N_S0_RB;
  localparam int unsigned NSH = IS_SIG1 ? N_S1_SH : N_S0_SH;
  localparam int unsigned WRA = IS_SIG1 ? W_S1_RA : W_S0_RA;
  localparam int unsigned WRB = IS_SIG1 ? W_S1_RB : W_S0_RB;
  localparam int unsigned WSH = IS_SIG1 ? W_S1_SH : W_S0_SH;

  half_t narrow_mix;
  lane_t wide_mix;

  always_comb begin
    narrow_mix = mix_half(x[HALF_W-1:0], NRA, NRB, NSH);
    wide_mix   = mix_lane(x, WRA, WRB, WSH);
  end

  assign y = (width == WIDTH_WIDE) ? wide_mix
                                   : {{(LANE_W-HALF_W){1'b0}}, narrow_mix};

endmodule

// File: rtl/sha2_sched_lane.sv
module sha2_sched_lane
  import sha2_sched_pkg::*;
(
  input  width_e width,
  input  lane_t  w_back16,
  input  lane_t  w_back15,
  input  lane_t  w_back7,
  input  lane_t  w_back2,
  output lane_t  w_next
);

  lane_t keep;
  lane_t m16, m15, m7, m2;
  lane_t s0_val, s1_val;
  lane_t raw_sum;

  always_comb begin
    keep = width_mask(width);
    m16  = w_back16 & keep;
    m15  = w_back15 & keep;
    m7   = w_back7  & keep;
    m2   = w_back2  & keep;
  end

  sha2_sigma #(.IS_SIG1(1'b0)) u_sig0 (.width(width), .x(m15), .y(s0_val));
  sha2_sigma #(.IS_SIG1(1'b1)) u_sig1 (.width(width), .x(m2),  .y(s1_val));

  assign raw_sum = s1_val + m7 + s0_val + m16;
  assign w_next  = raw_sum & keep;

endmodule

// File: rtl/sha2_sched_group.sv
module sha2_sched_group
  import sha2_sched_pkg::*;
#(
  parameter int unsigned N_WIN = WIN_N,
  parameter int unsigned N_OUT = GROUP_N
) (
  input  width_e                    width,
  input  logic [N_WIN*LANE_W-1:0]   window,
  output logic [N_OUT*LANE_W-1:0]   words
);

  localparam int unsigned OFS_NEAR = 1;
  localparam int unsigned OFS_MID  = N_WIN - 7;
  localparam int unsigned OFS_LATE = N_WIN - 2;

  lane_t win_w [N_WIN];
  lane_t new_w [N_OUT];

  for (genvar i = 0; i < N_WIN; i++) begin : g_unpack
    assign win_w[i] = window[i*LANE_W +: LANE_W];
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_lane
    lane_t late_src;
    if (k + OFS_LATE < N_WIN) begin : g_from_win
      assign late_src = win_w[k + OFS_LATE];
    end else begin : g_from_chain
      assign late_src = new_w[k + OFS_LATE - N_WIN];
    end

    sha2_sched_lane u_lane (
      .width    (width),
      .w_back16 (win_w[k]),
      .w_back15 (win_w[k + OFS_NEAR]),
      .w_back7  (win_w[k + OFS_MID]),
      .w_back2  (late_src),
      .w_next   (new_w[k])
    );

    assign words[k*LANE_W +: LANE_W] = new_w[k];
  end

endmodule

// File: rtl/sha2_sched_unit.sv
module sha2_sched_unit
  import sha2_sched_pkg::*;
#(
  parameter int unsigned N_WIN = WIN_N,
  parameter int unsigned N_OUT = GROUP_N
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_wide,
  input  logic [N_WIN*64-1:0]     req_window,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [N_OUT*64-1:0]     rsp_words
);

  localparam int unsigned OUT_BITS = N_OUT * LANE_W;

  width_e                width_in;
  logic [OUT_BITS-1:0]   next_words;
  width_e                held_width;

  // named events for the checks
  logic accept_evt;
  logic drain_evt;
  logic stall_evt;

  assign width_in   = req_wide ? WIDTH_WIDE : WIDTH_NARROW;
  assign req_ready  = !rsp_valid || rsp_ready;
  assign accept_evt = req_valid && req_ready;
  assign drain_evt  = rsp_valid && rsp_ready;
  assign stall_evt  = rsp_valid && !rsp_ready;

  sha2_sched_group #(.N_WIN(N_WIN), .N_OUT(N_OUT)) u_group (
    .width  (width_in),
    .window (req_window),
    .words  (next_words)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_words  <= '0;
      held_width <= WIDTH_NARROW;
    end else begin
      if (req_ready) rsp_valid <= req_valid;
      if (accept_evt) begin
        rsp_words  <= next_words;
        held_width <= width_in;
      end
    end
  end

  // R8
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt |=> rsp_valid && $stable(rsp_words));

  // R7
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> rsp_valid);

  // R9
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_evt && !req_valid |=> !rsp_valid);

  // R6
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  // R5
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && held_width == WIDTH_NARROW |->
      (rsp_words[0*64+32 +: 32] | rsp_words[1*64+32 +: 32] |
       rsp_words[2*64+32 +: 32] | rsp_words[3*64+32 +: 32]) == '0);

endmodule

// File: tb/test_sha2_sched_unit.sv
module test_sha2_sched_unit;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic           req_wide = 1'b0;
  logic [1023:0]  req_window = '0;
  logic           rsp_valid;
  logic           rsp_ready = 1'b0;
  logic [255:0]   rsp_words;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  int ready_mode = 0; // 0 random, 1 always high
  string cur_tag = "R1";

  logic [255:0] exp_q [$];
  logic         wide_q[$];
  string        tag_q [$];
  logic         acc_last = 1'b0;
  logic         stall_last = 1'b0;
  logic [255:0] prev_words;

  always #5 clk = ~clk;

  sha2_sched_unit i_sha2_sched_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wide(req_wide), .req_window(req_window), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_words(rsp_words)
  );

  // bench reference, written per bit position independently of the RTL
  function automatic logic [63:0] b_rot(input logic [63:0] x, input int n, input bit wide);
    logic [63:0] r = '0;
    int w = wide ? 64 : 32;
    for (int b = 0; b < w; b++) r[b] = x[(b + n) % w];
    return r;
  endfunction

  function automatic logic [63:0] b_shr(input logic [63:0] x, input int n, input bit wide);
    logic [63:0] r = '0;
    int w = wide ? 64 : 32;
    for (int b = 0; b + n < w; b++) r[b] = x[b + n];
    return r;
  endfunction

  function automatic logic [63:0] b_s0(input logic [63:0] x, input bit wide);
    if (wide) return b_rot(x, 1, 1) ^ b_rot(x, 8, 1) ^ b_shr(x, 7, 1);
    return b_rot(x, 7, 0) ^ b_rot(x, 18, 0) ^ b_shr(x, 3, 0);
  endfunction

  function automatic logic [63:0] b_s1(input logic [63:0] x, input bit wide);
    if (wide) return b_rot(x, 19, 1) ^ b_rot(x, 61, 1) ^ b_shr(x, 6, 1);
    return b_rot(x, 17, 0) ^ b_rot(x, 19, 0) ^ b_shr(x, 10, 0);
  endfunction

  function automatic logic [255:0] b_group(input logic [1023:0] win, input bit wide);
    logic [63:0] w [20];
    logic [255:0] r;
    for (int i = 0; i < 16; i++) begin
      w[i] = win[i*64 +: 64];
      if (!wide) w[i] = {32'h0, w[i][31:0]};
    end
    for (int j = 16; j < 20; j++) begin
      logic [63:0] s;
      s = b_s1(w[j-2], wide) + w[j-7] + b_s0(w[j-15], wide) + w[j-16];
      w[j] = wide ? s : {32'h0, s[31:0]};
      r[(j-16)*64 +: 64] = w[j];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor, samples at the falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      // R7: ready equation
      check(req_ready == (!rsp_valid || rsp_ready), "R7", "req_ready",
            {63'b0, req_ready}, {63'b0, !rsp_valid || rsp_ready});
      // R7: one-cycle latency
      if (acc_last) check(rsp_valid, "R7", "rsp_valid after accept", {63'b0, rsp_valid}, 64'd1);
      // R8: held while stalled
      if (stall_last) begin
        check(rsp_valid, "R8", "valid held", {63'b0, rsp_valid}, 64'd1);
        for (int k = 0; k < 4; k++)
          check(rsp_words[k*64 +: 64] == prev_words[k*64 +: 64], "R8", "word held",
                rsp_words[k*64 +: 64], prev_words[k*64 +: 64]);
      end
      // R9: exactly one response per accept
      check(rsp_valid == (exp_q.size() != 0), "R9", "response presence",
            {63'b0, rsp_valid}, {63'b0, exp_q.size() != 0});
      if (rsp_valid && exp_q.size() != 0) begin
        for (int k = 0; k < 4; k++) begin
          string t = (k >= 2) ? "R4" : tag_q[0];
          check(rsp_words[k*64 +: 64] == exp_q[0][k*64 +: 64], t, $sformatf("word %0d", k),
                rsp_words[k*64 +: 64], exp_q[0][k*64 +: 64]);
          if (!wide_q[0])
            check(rsp_words[k*64+32 +: 32] == 32'h0, "R5", $sformatf("upper of word %0d", k),
                  {32'h0, rsp_words[k*64+32 +: 32]}, 64'h0);
        end
        if (rsp_ready) begin
          void'(exp_q.pop_front());
          void'(wide_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
      stall_last = rsp_valid && !rsp_ready;
      prev_words = rsp_words;
      acc_last   = req_valid && req_ready;
      if (acc_last) begin
        exp_q.push_back(b_group(req_window, req_wide));
        wide_q.push_back(req_wide);
        tag_q.push_back(cur_tag);
      end
    end
  end

  // consumer
  always @(posedge clk) begin
    #1;
    if (ready_mode == 1) rsp_ready = 1'b1;
    else rsp_ready = ($urandom % 3) != 0;
  end

  task automatic send(input logic [1023:0] win, input bit wide, input string tag, input int gap);
    bit taken;
    req_window = win;
    req_wide   = wide;
    cur_tag    = tag;
    req_valid  = 1'b1;
    do begin
      @(negedge clk);
      taken = req_ready;
      @(posedge clk); #1;
    end while (!taken);
    req_valid = 1'b0;
    for (int g = 0; g < gap; g++) begin
      @(posedge clk); #1;
    end
  endtask

  function automatic logic [1023:0] rand_win();
    logic [1023:0] r;
    for (int i = 0; i < 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [1023:0] w;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    // R6: reset state
    check(!rsp_valid, "R6", "rsp_valid in reset", {63'b0, rsp_valid}, 64'd0);
    check(req_ready, "R6", "req_ready in reset", {63'b0, req_ready}, 64'd1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(!rsp_valid, "R6", "rsp_valid after reset", {63'b0, rsp_valid}, 64'd0);

    // directed corners
    send('0, 1'b0, "R1", 2);
    send('0, 1'b1, "R2", 2);
    send({1024{1'b1}}, 1'b1, "R3", 1);
    w = '0;
    for (int i = 0; i < 16; i++) w[i*64 +: 64] = {32'hDEADBEEF, 32'hFFFFFFFF};
    send(w, 1'b0, "R3", 1);
    w = '0;
    for (int i = 0; i < 16; i++) w[i*64 +: 64] = {32'hA5A5_0F0F, 32'h0};
    send(w, 1'b0, "R5", 1);
    w = '0;
    w[14*64 +: 64] = 64'h1;
    w[15*64 +: 64] = 64'h8000_0000_0000_0000;
    send(w, 1'b1, "R4", 1);
    w = '0;
    w[0] = 1'b1;
    w[1*64 +: 64] = 64'h8000_0001;
    send(w, 1'b0, "R4", 1);

    // random, mixed widths and gaps
    for (int n = 0; n < 400; n++) begin
      bit wd = $urandom % 2;
      send(rand_win(), wd, wd ? "R2" : "R1", $urandom % 3);
    end

    // back-to-back with consumer always ready
    ready_mode = 1;
    for (int n = 0; n < 100; n++) begin
      bit wd = $urandom % 2;
      send(rand_win(), wd, "R9", 0);
    end

    repeat (10) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R9", "all responses drained", exp_q.size(), 64'd0);
    finish_run();
  end

endmodule